// File: doc/BRIEF.md
# Dual-Port Row Conflict Arbiter

This block sits ahead of a small two-port memory array. Each port presents a row address and a write-request bit. The block expands both addresses into one-hot row-select vectors and compares them to see whether the two ports land on the same row. From that match and a static winner-select input it forms the final per-port enables. Those enables go straight to the array as each port's write strobe, so the two ports can never write one row in the same access.

A collision is settled in the same access, without stalling anyone. When both ports write the same row, the winner-select bit picks which one goes through. When one port writes and the other reads that row, the writer proceeds and the reader's enable is held low. Two reads of one row need no write strobe at all. The match flag is also exported so that the data path can steer the winning port's write data onto the shared row.

The parameter `REG_OUT` chooses the output timing. With `REG_OUT = 1` (the default), all outputs are registered: they appear one clock after the inputs are sampled and are cleared by reset. With `REG_OUT = 0`, the outputs are combinational.

Top module: `dpa_conflict_arbiter`

## Requirements
- R1: `row_a` has exactly one bit high, at bit position equal to the binary value of `addr_a`; `row_b` follows the same rule for `addr_b`.
- R2: `same_row` is 1 exactly when `addr_a` equals `addr_b`, and 0 otherwise.
- R3: When `same_row` is 0, `en_a` equals `wr_a` and `en_b` equals `wr_b`.
- R4: When `same_row` is 1 and both `wr_a` and `wr_b` are 0, both `en_a` and `en_b` are 0.
- R5: When `same_row` is 1 and both ports write, `win_sel` = 0 gives `en_a` = 1, `en_b` = 0, and `win_sel` = 1 gives `en_a` = 0, `en_b` = 1.
- R6: When `same_row` is 1 and exactly one port writes, that port's enable is 1 and the other port's enable is 0, whatever the value of `win_sel`.
- R7: `en_a` and `en_b` are never both 1 while `same_row` is 1.
- R8: With `REG_OUT` = 1, every output reflects the inputs sampled at the previous rising clock edge. While `rst_n` is low, all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the optional output register |
| rst_n | input | 1 | Active-low synchronous reset of the output register |
| addr_a | input | ADDR_W | Row address of port A |
| addr_b | input | ADDR_W | Row address of port B |
| wr_a | input | 1 | Port A write request (0 = read) |
| wr_b | input | 1 | Port B write request (0 = read) |
| win_sel | input | 1 | Winner select on a same-row double write (0 = A, 1 = B) |
| row_a | output | 2**ADDR_W | One-hot row select of port A |
| row_b | output | 2**ADDR_W | One-hot row select of port B |
| same_row | output | 1 | Both ports address the same row |
| en_a | output | 1 | Final write enable of port A |
| en_b | output | 1 | Final write enable of port B |

## Verification
In the default registered build, each output is due exactly one rising edge after its inputs are presented. The bench drives a new input set on a falling edge and compares all outputs on the following falling edge. This gives half a period of margin on both sides of the capturing edge. The sweep covers every combination of the two addresses, both write bits and the winner select. The reset value of every output is compared while reset is still held.

// File: rtl/dpa_pkg.sv
package dpa_pkg;

    typedef enum logic {
        WIN_PORT_A = 1'b0,
        WIN_PORT_B = 1'b1
    } dpa_winner_e;

    typedef struct packed {
        logic en_a;
        logic en_b;
    } dpa_grant_t;

endpackage

// File: rtl/dpa_row_decode.sv
module dpa_row_decode #(
    parameter int ADDR_W = 2,
    localparam int ROWS  = 1 << ADDR_W
) (
    input  logic [ADDR_W-1:0] addr,
    output logic [ROWS-1:0]   row
);

    for (genvar gi = 0; gi < ROWS; gi++) begin : g_row
        assign row[gi] = (addr == ADDR_W'(gi));
    end

endmodule

// File: rtl/dpa_row_match.sv
module dpa_row_match #(
    parameter int ROWS = 4
) (
    input  logic [ROWS-1:0] row_a,
    input  logic [ROWS-1:0] row_b,
    output logic            hit
);

    // Any row line high on both sides marks a shared target.
    assign hit = |(row_a & row_b);

endmodule

// File: rtl/dpa_grant.sv
module dpa_grant
    import dpa_pkg::*;
(
    input  logic        hit,
    input  logic        wr_a,
    input  logic        wr_b,
    input  dpa_winner_e winner,
    output dpa_grant_t  grant
);

    always_comb begin
        grant = '{en_a: wr_a, en_b: wr_b};
        if (hit && wr_a && wr_b) begin
            unique case (winner)
                WIN_PORT_A: grant = '{en_a: 1'b1, en_b: 1'b0};
                WIN_PORT_B: grant = '{en_a: 1'b0, en_b: 1'b1};
                default:    grant = '{en_a: 1'b0, en_b: 1'b0};
            endcase
        end
    end

endmodule

// File: rtl/dpa_conflict_arbiter.sv
module dpa_conflict_arbiter
    import dpa_pkg::*;
#(
    parameter int ADDR_W  = 2,
    parameter bit REG_OUT = 1'b1,
    localparam int ROWS   = 1 << ADDR_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr_a,
    input  logic [ADDR_W-1:0] addr_b,
    input  logic              wr_a,
    input  logic              wr_b,
    input  logic              win_sel,
    output logic [ROWS-1:0]   row_a,
    output logic [ROWS-1:0]   row_b,
    output logic              same_row,
    output logic              en_a,
    output logic              en_b
);

    logic [ROWS-1:0] dec_a;
    logic [ROWS-1:0] dec_b;
    logic            hit;
    dpa_grant_t      grant;
    dpa_winner_e     winner;

    assign winner = dpa_winner_e'(win_sel);

    dpa_row_decode #(.ADDR_W(ADDR_W)) u_dec_a (.addr(addr_a), .row(dec_a));
    dpa_row_decode #(.ADDR_W(ADDR_W)) u_dec_b (.addr(addr_b), .row(dec_b));

    dpa_row_match #(.ROWS(ROWS)) u_match (
        .row_a (dec_a),
        .row_b (dec_b),
        .hit   (hit)
    );

    dpa_grant u_grant (
        .hit    (hit),
        .wr_a   (wr_a),
        .wr_b   (wr_b),
        .winner (winner),
        .grant  (grant)
    );

    if (REG_OUT) begin : g_reg
        logic [ROWS-1:0] row_a_q;
        logic [ROWS-1:0] row_b_q;
        logic            same_q;
        dpa_grant_t      grant_q;

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                row_a_q <= '0;
                row_b_q <= '0;
                same_q  <= 1'b0;
                grant_q <= '0;
            end else begin
                row_a_q <= dec_a;
                row_b_q <= dec_b;
                same_q  <= hit;
                grant_q <= grant;
            end
        end

        assign row_a    = row_a_q;
        assign row_b    = row_b_q;
        assign same_row = same_q;
        assign en_a     = grant_q.en_a;
        assign en_b     = grant_q.en_b;
    end else begin : g_comb
        assign row_a    = dec_a;
        assign row_b    = dec_b;
        assign same_row = hit;
        assign en_a     = grant.en_a;
        assign en_b     = grant.en_b;
    end

endmodule

// File: rtl/dpa_conflict_arbiter_chk.sv
module dpa_conflict_arbiter_chk #(
    parameter int ADDR_W  = 2,
    parameter bit REG_OUT = 1'b1,
    localparam int ROWS   = 1 << ADDR_W
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] addr_a,
    input logic [ADDR_W-1:0] addr_b,
    input logic              wr_a,
    input logic              wr_b,
    input logic              win_sel,
    input logic [ROWS-1:0]   row_a,
    input logic [ROWS-1:0]   row_b,
    input logic              same_row,
    input logic              en_a,
    input logic              en_b
);

    logic [ADDR_W-1:0] s_addr_a;
    logic [ADDR_W-1:0] s_addr_b;
    logic              s_wr_a;
    logic              s_wr_b;
    logic              s_sel;
    logic              live;

    if (REG_OUT) begin : g_lag
        logic seen;
        always_ff @(posedge clk) begin
            if (!rst_n) seen <= 1'b0;
            else        seen <= 1'b1;
            s_addr_a <= addr_a;
            s_addr_b <= addr_b;
            s_wr_a   <= wr_a;
            s_wr_b   <= wr_b;
            s_sel    <= win_sel;
        end
        assign live = seen;
    end else begin : g_now
        assign s_addr_a = addr_a;
        assign s_addr_b = addr_b;
        assign s_wr_a   = wr_a;
        assign s_wr_b   = wr_b;
        assign s_sel    = win_sel;
        assign live     = 1'b1;
    end

    // R1
    a_r1_row_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        live |-> ($countones(row_a) == 1 && $countones(row_b) == 1
                 && row_a[s_addr_a] && row_b[s_addr_b]));

    // R2
    a_r2_match_flag: assert property (@(posedge clk) disable iff (!rst_n)
        live |-> (same_row == (s_addr_a == s_addr_b)));

    // R3
    a_r3_pass_through: assert property (@(posedge clk) disable iff (!rst_n)
        (live && !same_row) |-> (en_a == s_wr_a && en_b == s_wr_b));

    // R4
    a_r4_two_reads: assert property (@(posedge clk) disable iff (!rst_n)
        (live && same_row && !s_wr_a && !s_wr_b) |-> (!en_a && !en_b));

    // R5
    a_r5_double_write: assert property (@(posedge clk) disable iff (!rst_n)
        (live && same_row && s_wr_a && s_wr_b) |-> (en_a == !s_sel && en_b == s_sel));

    // R6
    a_r6_writer_keeps: assert property (@(posedge clk) disable iff (!rst_n)
        (live && same_row && (s_wr_a != s_wr_b)) |-> (en_a == s_wr_a && en_b == s_wr_b));

    // R7
    a_r7_no_dual_grant: assert property (@(posedge clk) disable iff (!rst_n)
        same_row |-> !(en_a && en_b));

    // R8
    a_r8_reset_clear: assert property (@(posedge clk)
        $past(!rst_n) && REG_OUT |-> (row_a == '0 && row_b == '0 && !same_row && !en_a && !en_b));

endmodule

bind dpa_conflict_arbiter dpa_conflict_arbiter_chk #(
    .ADDR_W  (ADDR_W),
    .REG_OUT (REG_OUT)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .addr_a   (addr_a),
    .addr_b   (addr_b),
    .wr_a     (wr_a),
    .wr_b     (wr_b),
    .win_sel  (win_sel),
    .row_a    (row_a),
    .row_b    (row_b),
    .same_row (same_row),
    .en_a     (en_a),
    .en_b     (en_b)
);

// File: tb/dpa_conflict_arbiter_bench.sv
`timescale 1ns/1ps
module dpa_conflict_arbiter_bench;

    localparam int ADDR_W = 2;
    localparam int ROWS   = 1 << ADDR_W;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [ADDR_W-1:0] addr_a = '0;
    logic [ADDR_W-1:0] addr_b = '0;
    logic              wr_a = 1'b0;
    logic              wr_b = 1'b0;
    logic              win_sel = 1'b0;
    logic [ROWS-1:0]   row_a;
    logic [ROWS-1:0]   row_b;
    logic              same_row;
    logic              en_a;
    logic              en_b;

    int n_run  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    dpa_conflict_arbiter #(.ADDR_W(ADDR_W), .REG_OUT(1'b1)) u_dpa_conflict_arbiter (
        .clk(clk), .rst_n(rst_n), .addr_a(addr_a), .addr_b(addr_b),
        .wr_a(wr_a), .wr_b(wr_b), .win_sel(win_sel),
        .row_a(row_a), .row_b(row_b), .same_row(same_row),
        .en_a(en_a), .en_b(en_b)
    );

    task automatic check(input string req, input int act, input int exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R8: reset state
        check("R8 row_a reset", int'(row_a), 0);
        check("R8 row_b reset", int'(row_b), 0);
        check("R8 same_row reset", int'(same_row), 0);
        check("R8 en reset", int'({en_a, en_b}), 0);
        rst_n = 1'b1;
        for (int v = 0; v < (1 << (2 * ADDR_W + 3)); v++) begin
            int aa, ab, wa, wb, sl, exp_a, exp_b, match;
            aa = v & (ROWS - 1);
            ab = (v >> ADDR_W) & (ROWS - 1);
            wa = (v >> (2 * ADDR_W)) & 1;
            wb = (v >> (2 * ADDR_W + 1)) & 1;
            sl = (v >> (2 * ADDR_W + 2)) & 1;
            @(negedge clk);
            addr_a = ADDR_W'(aa); addr_b = ADDR_W'(ab);
            wr_a = wa[0]; wr_b = wb[0]; win_sel = sl[0];
            @(negedge clk);
            match = (aa == ab) ? 1 : 0;
            if (!match) begin
                exp_a = wa; exp_b = wb;                 // R3
            end else if (wa == 1 && wb == 1) begin
                exp_a = 1 - sl; exp_b = sl;             // R5
            end else begin
                exp_a = wa; exp_b = wb;                 // R4, R6
            end
            check("R1 row_a", int'(row_a), 1 << aa);
            check("R1 row_b", int'(row_b), 1 << ab);
            check("R2 same_row", int'(same_row), match);
            if (!match)
                check("R3 en_a/en_b", int'({en_a, en_b}), exp_a * 2 + exp_b);
            else if (wa == 0 && wb == 0)
                check("R4 en_a/en_b", int'({en_a, en_b}), 0);
            else if (wa == 1 && wb == 1)
                check("R5 en_a/en_b", int'({en_a, en_b}), exp_a * 2 + exp_b);
            else
                check("R6 en_a/en_b", int'({en_a, en_b}), exp_a * 2 + exp_b);
            check("R7 no dual grant", int'(same_row && en_a && en_b), 0);
        end
        // R8: registered latency, output must still show the prior set before edge
        @(negedge clk);
        addr_a = 2'd1; addr_b = 2'd1; wr_a = 1'b1; wr_b = 1'b1; win_sel = 1'b1;
        @(posedge clk); #1;
        addr_a = 2'd2; addr_b = 2'd3; wr_a = 1'b0; wr_b = 1'b0;
        @(negedge clk);
        check("R8 one-cycle row_a", int'(row_a), 2);
        check("R8 one-cycle en", int'({en_a, en_b}), 1);
        @(negedge clk);
        check("R8 next row_a", int'(row_a), 4);
        check("R8 next same_row", int'(same_row), 0);
        // R8: reset clears live outputs
        rst_n = 1'b0;
        @(negedge clk);
        check("R8 reset clears", int'({row_a, row_b, same_row, en_a, en_b}), 0);
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

endmodule